// File: doc/BRIEF.md
# Line-Tagged Stall-and-Replay Request Arbiter

This block sits in front of a cache-line coherence controller. It hands the controller one message per cycle. It picks that message from three valid/ready inputs by a fixed priority: returning responses first, then requests forwarded from the shared level, and processor requests last. A processor request that arrives while its cache line is mid-transaction is not bounced back or retried after a timer. The block takes it into a small side store and tags it with the line address.

A parked request stays put until the controller announces, with an address-tagged wake pulse, that the line has settled. On that pulse every parked entry for the line becomes eligible. Eligible entries then go to the controller one per cycle, oldest first, ahead of anything still waiting on the processor input. A later processor request to a line that still has parked entries is parked behind them, so younger traffic to a line can never overtake older traffic and starve it. Lines with nothing parked keep flowing.

The controller answers a combinational lookup that says whether a given line is transient. The block asks about the processor request at the head of the input, or about the oldest eligible entry when one exists. If a woken entry finds its line transient again, it goes back to waiting.

Top module: `addr_stall_arbiter`

## Requirements
- R1: Each cycle at most one message is granted, with priority response > forward > processor side. `rsp_ready` is always 1. `fwd_ready` is 0 whenever `rsp_valid` is 1. `cpu_ready` is 0 whenever `rsp_valid` or `fwd_valid` is 1.
- R2: A message accepted at a clock edge appears on the grant outputs right after that edge, for one cycle. The source code is 2 for a response, 1 for a forward and 0 for the processor side. `grant_addr` carries its address. `grant_op` carries the processor op code (0 load, 1 ifetch, 2 store, 3 evict) and is 0 for responses and forwards.
- R3: A processor request accepted while `lk_transient` is 1 for its address is parked and produces no grant.
- R4: A processor request whose address matches any parked entry is parked behind it, even when its line is reported stable.
- R5: While entries are parked, processor requests to other, stable lines are accepted and granted normally.
- R6: A parked entry is never granted without a wake pulse for its address. A wake pulse for an address with no parked entry changes nothing.
- R7: After a wake pulse for an address, all parked entries for it are granted oldest first, one per cycle, starting the cycle after the pulse. They go ahead of any processor request still waiting on the input.
- R8: An eligible entry whose line is transient at its turn is not granted. It keeps its place in age order and waits for a new wake pulse.
- R9: With DEPTH entries parked, `cpu_ready` is 0 for any request that would need parking, and requests are never dropped. A request to a stable line with no parked entries is still accepted.
- R10: Responses and forwards are never parked, whatever the state of their line.
- R11: After reset `grant_valid` is 0 and the store is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| rsp_valid | input | 1 | response present |
| rsp_addr | input | ADDR_W | response line address |
| rsp_ready | output | 1 | response taken |
| fwd_valid | input | 1 | forwarded request present |
| fwd_addr | input | ADDR_W | forwarded request line address |
| fwd_ready | output | 1 | forwarded request taken |
| cpu_valid | input | 1 | processor request present |
| cpu_addr | input | ADDR_W | processor request line address |
| cpu_op | input | 2 | processor op code |
| cpu_ready | output | 1 | processor request taken (granted or parked) |
| lk_addr | output | ADDR_W | line address being looked up |
| lk_transient | input | 1 | looked-up line is mid-transaction |
| wake_valid | input | 1 | wake pulse |
| wake_addr | input | ADDR_W | line that has settled |
| grant_valid | output | 1 | grant present this cycle |
| grant_src | output | 2 | grant source code |
| grant_addr | output | ADDR_W | granted line address |
| grant_op | output | 2 | granted processor op code |

## Verification
The ready outputs are combinational, so the bench reads them 1 ns after the falling edge at which it drives the inputs, before the accepting edge. A grant is due right after the edge that accepts its message, and the monitor samples it 2 ns after each rising edge and pops the expected item from a scoreboard queue. A replay is due one edge after the edge that captured the wake pulse, with the next one an edge later. The bench checks those exact cycles directly, and it counts grants over idle windows to show that parked entries stay parked.

// File: rtl/asa_pkg.sv
package asa_pkg;

    typedef enum logic [1:0] {
        SRC_PROC = 2'd0,
        SRC_FWD  = 2'd1,
        SRC_RSP  = 2'd2
    } src_e;

    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_IFETCH = 2'd1,
        OP_STORE  = 2'd2,
        OP_EVICT  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_RSP,
        ACT_FWD,
        ACT_REPLAY,
        ACT_REPARK,
        ACT_CPU_GO,
        ACT_CPU_PARK
    } act_e;

    function automatic logic must_wait(input logic transient, input logic line_hit);
        return transient | line_hit;
    endfunction

    function automatic logic act_grants(input act_e a);
        return (a == ACT_RSP) || (a == ACT_FWD) || (a == ACT_REPLAY) || (a == ACT_CPU_GO);
    endfunction

endpackage

// File: rtl/asa_stall_buf.sv
module asa_stall_buf
    import asa_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  op_e               push_op,
    input  logic              pop,
    input  logic              repark,
    input  logic              wake_valid,
    input  logic [ADDR_W-1:0] wake_addr,
    input  logic [ADDR_W-1:0] cmp_addr,
    output logic              line_hit,
    output logic              full,
    output logic              cand_valid,
    output logic [ADDR_W-1:0] cand_addr,
    output op_e               cand_op,
    output logic [CNT_W-1:0]  fill_cnt
);

    typedef struct packed {
        logic              live;
        logic              armed;
        logic [ADDR_W-1:0] addr;
        op_e               op;
    } slot_t;

    slot_t            slots_q [DEPTH];
    slot_t            nxt     [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [DEPTH-1:0] armed_vec, hit_vec, wake_vec;
    logic [IDX_W-1:0] cand_idx;
    logic [IDX_W-1:0] tail_idx;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign armed_vec[g] = slots_q[g].live && slots_q[g].armed;
        assign hit_vec[g]   = slots_q[g].live && (slots_q[g].addr == cmp_addr);
        assign wake_vec[g]  = slots_q[g].live && wake_valid && (slots_q[g].addr == wake_addr);
    end

    // oldest armed entry: lowest index, since entries stay packed in age order
    always_comb begin
        cand_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (armed_vec[i]) cand_idx = IDX_W'(i);
        end
    end

    assign cand_valid = |armed_vec;
    assign cand_addr  = slots_q[cand_idx].addr;
    assign cand_op    = slots_q[cand_idx].op;
    assign line_hit   = |hit_vec;
    assign full       = (cnt_q == CNT_W'(DEPTH));
    assign fill_cnt   = cnt_q;
    assign tail_idx   = cnt_q[IDX_W-1:0];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) nxt[i] = slots_q[i];
        if (repark) nxt[cand_idx].armed = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (wake_vec[i]) nxt[i].armed = 1'b1;
        end
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (i >= int'(cand_idx)) nxt[i] = nxt[i + 1];
            end
            nxt[DEPTH-1] = '0;
        end
        if (push) begin
            nxt[tail_idx].live  = 1'b1;
            nxt[tail_idx].armed = wake_valid && (wake_addr == push_addr);
            nxt[tail_idx].addr  = push_addr;
            nxt[tail_idx].op    = push_op;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) slots_q[i] <= '0;
            cnt_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) slots_q[i] <= nxt[i];
            if (push && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (pop && !push) cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/asa_port_arb.sv
module asa_port_arb
    import asa_pkg::*;
(
    input  logic rsp_valid,
    input  logic fwd_valid,
    input  logic cpu_valid,
    input  logic cand_valid,
    input  logic lk_transient,
    input  logic line_hit,
    input  logic full,
    output logic rsp_ready,
    output logic fwd_ready,
    output logic cpu_ready,
    output act_e act
);

    logic wait_line;

    assign wait_line = must_wait(lk_transient, line_hit);

    always_comb begin
        act       = ACT_IDLE;
        rsp_ready = 1'b1;
        fwd_ready = !rsp_valid;
        cpu_ready = 1'b0;
        if (rsp_valid) begin
            act = ACT_RSP;
        end else if (fwd_valid) begin
            act = ACT_FWD;
        end else if (cand_valid) begin
            act = lk_transient ? ACT_REPARK : ACT_REPLAY;
        end else begin
            cpu_ready = !wait_line || !full;
            if (cpu_valid) begin
                if (!wait_line)  act = ACT_CPU_GO;
                else if (!full)  act = ACT_CPU_PARK;
            end
        end
    end

endmodule

// File: rtl/addr_stall_arbiter.sv
module addr_stall_arbiter
    import asa_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rsp_valid,
    input  logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_ready,
    input  logic              fwd_valid,
    input  logic [ADDR_W-1:0] fwd_addr,
    output logic              fwd_ready,
    input  logic              cpu_valid,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [1:0]        cpu_op,
    output logic              cpu_ready,
    output logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_transient,
    input  logic              wake_valid,
    input  logic [ADDR_W-1:0] wake_addr,
    output logic              grant_valid,
    output logic [1:0]        grant_src,
    output logic [ADDR_W-1:0] grant_addr,
    output logic [1:0]        grant_op
);

    typedef struct packed {
        logic              valid;
        src_e              src;
        logic [ADDR_W-1:0] addr;
        op_e               op;
    } grant_t;

    act_e              act;
    logic              line_hit, full, cand_valid;
    logic [ADDR_W-1:0] cand_addr;
    op_e               cand_op;
    logic [CNT_W-1:0]  fill_cnt;
    grant_t            grant_q;

    assign lk_addr = cand_valid ? cand_addr : cpu_addr;

    asa_stall_buf #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_buf (
        .clk        (clk),
        .rst        (rst),
        .push       (act == ACT_CPU_PARK),
        .push_addr  (cpu_addr),
        .push_op    (op_e'(cpu_op)),
        .pop        (act == ACT_REPLAY),
        .repark     (act == ACT_REPARK),
        .wake_valid (wake_valid),
        .wake_addr  (wake_addr),
        .cmp_addr   (cpu_addr),
        .line_hit   (line_hit),
        .full       (full),
        .cand_valid (cand_valid),
        .cand_addr  (cand_addr),
        .cand_op    (cand_op),
        .fill_cnt   (fill_cnt)
    );

    asa_port_arb u_arb (
        .rsp_valid    (rsp_valid),
        .fwd_valid    (fwd_valid),
        .cpu_valid    (cpu_valid),
        .cand_valid   (cand_valid),
        .lk_transient (lk_transient),
        .line_hit     (line_hit),
        .full         (full),
        .rsp_ready    (rsp_ready),
        .fwd_ready    (fwd_ready),
        .cpu_ready    (cpu_ready),
        .act          (act)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '{valid: 1'b0, src: SRC_PROC, addr: '0, op: OP_LOAD};
        end else begin
            grant_q.valid <= act_grants(act);
            unique case (act)
                ACT_RSP:    begin grant_q.src <= SRC_RSP;  grant_q.addr <= rsp_addr;  grant_q.op <= OP_LOAD; end
                ACT_FWD:    begin grant_q.src <= SRC_FWD;  grant_q.addr <= fwd_addr;  grant_q.op <= OP_LOAD; end
                ACT_REPLAY: begin grant_q.src <= SRC_PROC; grant_q.addr <= cand_addr; grant_q.op <= cand_op; end
                ACT_CPU_GO: begin grant_q.src <= SRC_PROC; grant_q.addr <= cpu_addr;  grant_q.op <= op_e'(cpu_op); end
                default: ;
            endcase
        end
    end

    assign grant_valid = grant_q.valid;
    assign grant_src   = grant_q.src;
    assign grant_addr  = grant_q.addr;
    assign grant_op    = grant_q.op;

endmodule

// File: rtl/asa_checker.sv
module asa_checker
    import asa_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              rsp_valid,
    input logic              fwd_valid,
    input logic              fwd_ready,
    input logic [ADDR_W-1:0] fwd_addr,
    input logic              cpu_valid,
    input logic              cpu_ready,
    input logic              lk_transient,
    input logic              line_hit,
    input logic [CNT_W-1:0]  fill_cnt,
    input logic              grant_valid,
    input logic [1:0]        grant_src,
    input logic [ADDR_W-1:0] grant_addr
);

    // R1
    rsp_first_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> (grant_valid && grant_src == SRC_RSP));

    // R10
    fwd_direct_chk: assert property (@(posedge clk) disable iff (rst)
        (fwd_valid && fwd_ready) |=>
            (grant_valid && grant_src == SRC_FWD && grant_addr == $past(fwd_addr)));

    // R3
    park_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && cpu_ready && lk_transient) |=> !grant_valid);

    // R4
    behind_older_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && cpu_ready && line_hit) |=> !grant_valid);

    // R9
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_cnt == CNT_W'(DEPTH) && cpu_valid && (lk_transient || line_hit)) |-> !cpu_ready);

    // R9
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_cnt == CNT_W'(DEPTH)) |=> (fill_cnt <= CNT_W'(DEPTH)));

endmodule

bind addr_stall_arbiter asa_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rsp_valid    (rsp_valid),
    .fwd_valid    (fwd_valid),
    .fwd_ready    (fwd_ready),
    .fwd_addr     (fwd_addr),
    .cpu_valid    (cpu_valid),
    .cpu_ready    (cpu_ready),
    .lk_transient (lk_transient),
    .line_hit     (line_hit),
    .fill_cnt     (fill_cnt),
    .grant_valid  (grant_valid),
    .grant_src    (grant_src),
    .grant_addr   (grant_addr)
);

// File: tb/addr_stall_arbiter_tb.sv
module addr_stall_arbiter_tb;

    localparam int AW = 16;
    localparam int DP = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rsp_valid = 1'b0, fwd_valid = 1'b0, cpu_valid = 1'b0, wake_valid = 1'b0;
    logic [AW-1:0] rsp_addr = '0, fwd_addr = '0, cpu_addr = '0, wake_addr = '0;
    logic [1:0]    cpu_op = '0;
    logic          rsp_ready, fwd_ready, cpu_ready, lk_transient;
    logic [AW-1:0] lk_addr, grant_addr;
    logic          grant_valid;
    logic [1:0]    grant_src, grant_op;
    logic [15:0]   busy = '0;

    int total = 0;
    int bad = 0;
    int n_grants = 0;
    bit finished = 0;

    typedef struct {
        logic [1:0]    src;
        logic [AW-1:0] addr;
        logic [1:0]    op;
        string         req;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    // the bench plays the controller: a set of lines that are mid-transaction
    assign lk_transient = busy[lk_addr[3:0]] && (lk_addr[AW-1:4] == '0);

    addr_stall_arbiter #(.ADDR_W(AW), .DEPTH(DP)) u_dut (
        .clk(clk), .rst(rst),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_ready(rsp_ready),
        .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_ready(fwd_ready),
        .cpu_valid(cpu_valid), .cpu_addr(cpu_addr), .cpu_op(cpu_op), .cpu_ready(cpu_ready),
        .lk_addr(lk_addr), .lk_transient(lk_transient),
        .wake_valid(wake_valid), .wake_addr(wake_addr),
        .grant_valid(grant_valid), .grant_src(grant_src),
        .grant_addr(grant_addr), .grant_op(grant_op)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic expect_grant(input logic [1:0] src, input logic [AW-1:0] a,
                                input logic [1:0] op, input string req);
        exp_t e;
        e.src = src; e.addr = a; e.op = op; e.req = req;
        sb.push_back(e);
    endtask

    // monitor: every grant must match the head of the scoreboard
    always @(posedge clk) begin
        #2;
        if (!rst && grant_valid) begin
            n_grants++;
            if (sb.size() == 0) begin
                chk(1'b0, "R6", "unexpected grant addr", int'(grant_addr), -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(grant_src == e.src && grant_addr == e.addr && grant_op == e.op, e.req,
                    "grant {src,addr,op}", int'({grant_src, grant_addr, grant_op}),
                    int'({e.src, e.addr, e.op}));
            end
        end
    end

    task automatic cpu_send(input logic [AW-1:0] a, input logic [1:0] op,
                            input bit parks, input string req);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_addr = a; cpu_op = op;
        #1;
        while (!cpu_ready) begin
            @(negedge clk);
            #1;
        end
        if (!parks) expect_grant(2'd0, a, op, req);
        @(posedge clk);
        #1 cpu_valid = 1'b0;
    endtask

    task automatic rsp_send(input logic [AW-1:0] a, input string req);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_addr = a;
        expect_grant(2'd2, a, 2'd0, req);
        @(posedge clk);
        #1 rsp_valid = 1'b0;
    endtask

    task automatic fwd_send(input logic [AW-1:0] a, input string req);
        @(negedge clk);
        fwd_valid = 1'b1; fwd_addr = a;
        #1;
        while (!fwd_ready) begin
            @(negedge clk);
            #1;
        end
        expect_grant(2'd1, a, 2'd0, req);
        @(posedge clk);
        #1 fwd_valid = 1'b0;
    endtask

    task automatic wake(input logic [AW-1:0] a);
        @(negedge clk);
        wake_valid = 1'b1; wake_addr = a;
        @(posedge clk);
        #1 wake_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int g0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R11: nothing granted, store empty so a stable line is accepted
        chk(grant_valid == 1'b0, "R11", "grant_valid after reset", int'(grant_valid), 0);
        chk(cpu_ready == 1'b1, "R11", "cpu_ready after reset", int'(cpu_ready), 1);

        // R2: grant due right after the accepting edge
        cpu_send(16'h0002, 2'd1, 0, "R2");
        #1;
        chk(grant_valid == 1'b1 && grant_src == 2'd0, "R2", "grant one edge after accept",
            int'(grant_valid), 1);
        @(posedge clk); #2;
        chk(grant_valid == 1'b0, "R2", "grant lasts one cycle", int'(grant_valid), 0);

        // R1: all three inputs at once
        @(negedge clk);
        rsp_valid = 1'b1; rsp_addr = 16'h0010;
        fwd_valid = 1'b1; fwd_addr = 16'h0011;
        cpu_valid = 1'b1; cpu_addr = 16'h0012; cpu_op = 2'd2;
        #1;
        chk(rsp_ready && !fwd_ready && !cpu_ready, "R1", "readies with response",
            int'({rsp_ready, fwd_ready, cpu_ready}), 3'b100);
        expect_grant(2'd2, 16'h0010, 2'd0, "R1");
        @(negedge clk);
        rsp_valid = 1'b0;
        #1;
        chk(fwd_ready && !cpu_ready, "R1", "readies with forward",
            int'({fwd_ready, cpu_ready}), 2'b10);
        expect_grant(2'd1, 16'h0011, 2'd0, "R1");
        @(negedge clk);
        fwd_valid = 1'b0;
        #1;
        chk(cpu_ready == 1'b1, "R1", "processor ready when alone", int'(cpu_ready), 1);
        expect_grant(2'd0, 16'h0012, 2'd2, "R1");
        @(negedge clk);
        cpu_valid = 1'b0;
        repeat (2) @(posedge clk);

        // R3 / R4 / R5 / R6 / R7
        busy[5] = 1'b1;
        cpu_send(16'h0005, 2'd2, 1, "R3");
        busy[5] = 1'b0;
        cpu_send(16'h0005, 2'd0, 1, "R4");
        cpu_send(16'h0007, 2'd1, 0, "R5");
        repeat (2) @(posedge clk);
        #2 g0 = n_grants;
        repeat (20) @(posedge clk);
        #2;
        chk(n_grants == g0, "R6", "no replay without wake", n_grants, g0);
        expect_grant(2'd0, 16'h0005, 2'd2, "R7");
        expect_grant(2'd0, 16'h0005, 2'd0, "R7");
        wake(16'h0005);
        @(posedge clk); #2;
        chk(grant_valid && grant_op == 2'd2, "R7", "oldest replay one edge after wake",
            int'({grant_valid, grant_op}), 3'b110);
        @(posedge clk); #2;
        chk(grant_valid && grant_op == 2'd0, "R7", "second replay next cycle",
            int'({grant_valid, grant_op}), 3'b100);
        repeat (2) @(posedge clk);

        // R10: line transient, response and forward still pass
        busy[5] = 1'b1;
        rsp_send(16'h0005, "R10");
        fwd_send(16'h0005, "R10");
        busy[5] = 1'b0;
        repeat (2) @(posedge clk);

        // R8 and R6 (wake with no match)
        busy[6] = 1'b1;
        cpu_send(16'h0006, 2'd2, 1, "R8");
        cpu_send(16'h0006, 2'd0, 1, "R8");
        busy[6] = 1'b0;
        expect_grant(2'd0, 16'h0006, 2'd2, "R8");
        wake(16'h0006);
        @(posedge clk);
        #1 busy[6] = 1'b1;
        @(posedge clk); #2 g0 = n_grants;
        wake(16'h0009);
        repeat (10) @(posedge clk);
        #2;
        chk(n_grants == g0, "R8", "re-parked entry stays put", n_grants, g0);
        chk(n_grants == g0, "R6", "unmatched wake has no effect", n_grants, g0);
        busy[6] = 1'b0;
        expect_grant(2'd0, 16'h0006, 2'd0, "R8");
        wake(16'h0006);
        repeat (3) @(posedge clk);
        #2;
        chk(n_grants == g0 + 1, "R8", "released after new wake", n_grants, g0 + 1);

        // R9: fill the store, stable unrelated line still flows
        busy[3] = 1'b1;
        for (int i = 0; i < DP; i++) cpu_send(16'h0003, 2'(i), 1, "R9");
        cpu_send(16'h0004, 2'd2, 0, "R9");
        fork
            cpu_send(16'h0003, 2'd3, 0, "R7");
            begin
                repeat (5) begin
                    @(negedge clk); #2;
                    chk(cpu_ready == 1'b0, "R9", "cpu_ready while full", int'(cpu_ready), 0);
                end
                busy[3] = 1'b0;
                for (int i = 0; i < DP; i++) expect_grant(2'd0, 16'h0003, 2'(i), "R7");
                wake(16'h0003);
            end
        join
        repeat (4) @(posedge clk);
        #2;
        chk(sb.size() == 0, "R6", "all expected grants seen", sb.size(), 0);
        finish_run();
    end

endmodule